// File: doc/BRIEF.md
# Periodic Interval Timer with Prescaler

This block is a software-programmed countdown timer that produces a repeating event. A 32-bit down-counter is decremented once per prescaler period. The prescaler divides either the system clock or a slower, separate timer clock by a programmable ratio. When the count reaches zero, an event flag is raised. On the next tick the counter reloads from the load register, so the timer runs periodically. The interrupt output follows the event flag only when the interrupt-mask bit allows it. Software clears the flag by writing 1 to it.

Software drives the block through a small word-addressed register bus. Writes are strobed and reads are combinational. The expected setup order is:
1. Write the prescaler.
2. Write the load value.
3. Write the control word, which holds the enable, interrupt-mask and clock-select bits.

Clearing the enable bit freezes the count. Setting it again resumes counting from the frozen value. The counting state machine has three states:
- `ST_IDLE`: enable is off and the count is held.
- `ST_COUNT`: the count is non-zero and is decremented on each tick.
- `ST_EXPIRED`: the count is zero, and the next tick reloads it.

The state machine has these transitions:
- Any state goes to `ST_IDLE` when enable is 0.
- `ST_IDLE` goes to `ST_COUNT` (count non-zero) or to `ST_EXPIRED` (count zero) when enable is 1.
- `ST_COUNT` goes to `ST_EXPIRED` on a tick while the count is 1.
- `ST_EXPIRED` goes to `ST_COUNT` on a tick when the load value is non-zero. With a zero load value it stays in `ST_EXPIRED` and raises the event again.
- A load-register write while enabled forces `ST_COUNT`, or `ST_EXPIRED` if the written value is 0.

Top module: `periodic_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. The registers are: control (address 0), prescaler (1), load (2), count (3) and event (4).
- R2: A write to address 2 sets both the load register and the count register to the written value.
- R3: With prescaler 0 and internal clock, the count reaches zero, and the event flag rises, exactly 1+L clock edges after the edge that writes enable (control bit 0) to 1. L is the count value.
- R4: With prescaler value P, each decrement takes P+1 source clock cycles, so zero is reached 1+L*(P+1) edges after the enabling write.
- R5: While control bit 0 is 0, the count holds its value. After re-enabling, counting resumes from the held value without reloading. The first decrement comes two edges after the enabling write.
- R6: Reaching zero sets event bit 0. When control bit 1 (interrupt mask) is 1, `irq` is asserted.
- R7: With control bit 1 at 0, the event flag is still set on reaching zero but `irq` stays low. Setting the mask bit later makes `irq` follow the pending flag.
- R8: Writing 1 to event bit 0 clears the flag and drops `irq`. Writing 0 leaves the flag set.
- R9: On the tick after the count reaches zero, the count reloads the load-register value.
- R10: With control bit 2 at 1, the count decrements once per rising edge of `tmr_clk_i`, after a two-flop synchronizer. It holds while that input has no edges.
- R11: The count register is read-only. Writes to unmapped addresses (5 to 7) change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_clk_i | input | 1 | Separate timer clock, slower than half of clk |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not selected |
| irq | output | 1 | Interrupt: event flag AND mask bit |

## Verification
The hardest situation to reach is a freeze in the middle of a count, followed by a resume. The bench has to place the disabling write on a known edge, so that it can predict the exact frozen value. It then has to show that the count neither creeps during the hold nor reloads on resume. Edge-exact write timing from a known enable point provides this: the frozen value and the value a few edges after resuming are both computed in advance. The separate timer clock is driven with slow, widely spaced pulses, so that each rising edge can be matched to exactly one decrement through the synchronizer.

// File: rtl/periodic_timer_pkg.sv
`timescale 1ns/1ps
package periodic_timer_pkg;

    localparam int unsigned ADR_CTRL  = 0;
    localparam int unsigned ADR_PSC   = 1;
    localparam int unsigned ADR_LOAD  = 2;
    localparam int unsigned ADR_COUNT = 3;
    localparam int unsigned ADR_EVENT = 4;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MASK_BIT = 1;
    localparam int unsigned CTRL_SEL_BIT  = 2;
    localparam int unsigned CTRL_BITS     = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/pt_regbank.sv
`timescale 1ns/1ps
module pt_regbank
    import periodic_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              zero_evt,
    output logic              ctrl_en,
    output logic              ctrl_mask,
    output logic              ctrl_extclk,
    output logic [PSC_W-1:0]  psc_val,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_wr,
    output logic              psc_wr,
    output logic              evt_flag
);

    logic                 wr_hit;
    logic                 ctrl_wr;
    logic                 evt_wr;
    logic [CTRL_BITS-1:0] ctrl_q;
    logic [PSC_W-1:0]     psc_q;
    logic [CNT_W-1:0]     load_q;
    logic                 flag_q;
    logic [31:0]          addr_ext;

    assign addr_ext = 32'(bus_addr);
    assign wr_hit   = bus_sel && bus_wr;
    assign ctrl_wr  = wr_hit && (addr_ext == ADR_CTRL);
    assign psc_wr   = wr_hit && (addr_ext == ADR_PSC);
    assign load_wr  = wr_hit && (addr_ext == ADR_LOAD);
    assign evt_wr   = wr_hit && (addr_ext == ADR_EVENT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            psc_q  <= '0;
            load_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_BITS-1:0];
            if (psc_wr)  psc_q  <= bus_wdata[PSC_W-1:0];
            if (load_wr) load_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Event flag: a new zero event wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (zero_evt) begin
            flag_q <= 1'b1;
        end else if (evt_wr && bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (addr_ext)
                ADR_CTRL:  bus_rdata = DATA_W'(ctrl_q);
                ADR_PSC:   bus_rdata = DATA_W'(psc_q);
                ADR_LOAD:  bus_rdata = DATA_W'(load_q);
                ADR_COUNT: bus_rdata = DATA_W'(cnt_val);
                ADR_EVENT: bus_rdata = DATA_W'(flag_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign ctrl_en     = ctrl_q[CTRL_EN_BIT];
    assign ctrl_mask   = ctrl_q[CTRL_MASK_BIT];
    assign ctrl_extclk = ctrl_q[CTRL_SEL_BIT];
    assign psc_val     = psc_q;
    assign load_val    = load_q;
    assign evt_flag    = flag_q;

endmodule

// File: rtl/pt_tick_gen.sv
`timescale 1ns/1ps
module pt_tick_gen #(
    parameter int unsigned PSC_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             use_ext,
    input  logic             ext_clk,
    input  logic [PSC_W-1:0] psc_val,
    input  logic             psc_wr,
    output logic             tick
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   edge_q;
    logic                   ext_pulse;
    logic                   src_pulse;
    logic [PSC_W-1:0]       pre_cnt;
    logic                   wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_clk;
    end

    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= 1'b0;
        else        edge_q <= sync_q[LAST];
    end

    assign ext_pulse = sync_q[LAST] && !edge_q;
    assign src_pulse = use_ext ? ext_pulse : 1'b1;
    assign wrap      = (pre_cnt >= psc_val);
    assign tick      = run && src_pulse && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (psc_wr) begin
            pre_cnt <= '0;
        end else if (run && src_pulse) begin
            pre_cnt <= wrap ? '0 : pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pt_count_fsm.sv
`timescale 1ns/1ps
module pt_count_fsm
    import periodic_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic [CNT_W-1:0] load_val,
    output logic             run,
    output logic             zero_evt,
    output logic [CNT_W-1:0] cnt_val,
    output cnt_state_e       state
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!ctrl_en) begin
            state_d = ST_IDLE;
        end else if (load_wr) begin
            state_d = (load_wdata == '0) ? ST_EXPIRED : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = (cnt_q == '0) ? ST_EXPIRED : ST_COUNT;
                ST_COUNT:   if (tick && cnt_q == ONE) state_d = ST_EXPIRED;
                ST_EXPIRED: if (tick && load_val != '0) state_d = ST_COUNT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        run      = ctrl_en && (state_q != ST_IDLE);
        zero_evt = 1'b0;
        if (!load_wr && tick) begin
            unique case (state_q)
                ST_COUNT:   zero_evt = (cnt_q == ONE);
                ST_EXPIRED: zero_evt = (load_val == '0);
                default:    zero_evt = 1'b0;
            endcase
        end
    end

    // Count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= load_wdata;
        end else if (tick && state_q == ST_COUNT && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end else if (tick && state_q == ST_EXPIRED) begin
            cnt_q <= load_val;
        end
    end

    assign cnt_val = cnt_q;
    assign state   = state_q;

endmodule

// File: rtl/periodic_timer.sv
`timescale 1ns/1ps
module periodic_timer
    import periodic_timer_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned PSC_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_clk_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned CNT_W = DATA_W;

    logic             ctrl_en;
    logic             ctrl_mask;
    logic             ctrl_extclk;
    logic [PSC_W-1:0] psc_val;
    logic [CNT_W-1:0] load_val;
    logic             load_wr;
    logic             psc_wr;
    logic             evt_flag;
    logic             run;
    logic             tick;
    logic             zero_evt;
    logic [CNT_W-1:0] cnt_val;
    cnt_state_e       state;

    pt_regbank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PSC_W  (PSC_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_val     (cnt_val),
        .zero_evt    (zero_evt),
        .ctrl_en     (ctrl_en),
        .ctrl_mask   (ctrl_mask),
        .ctrl_extclk (ctrl_extclk),
        .psc_val     (psc_val),
        .load_val    (load_val),
        .load_wr     (load_wr),
        .psc_wr      (psc_wr),
        .evt_flag    (evt_flag)
    );

    pt_tick_gen #(
        .PSC_W       (PSC_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .use_ext (ctrl_extclk),
        .ext_clk (tmr_clk_i),
        .psc_val (psc_val),
        .psc_wr  (psc_wr),
        .tick    (tick)
    );

    pt_count_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_en    (ctrl_en),
        .tick       (tick),
        .load_wr    (load_wr),
        .load_wdata (bus_wdata),
        .load_val   (load_val),
        .run        (run),
        .zero_evt   (zero_evt),
        .cnt_val    (cnt_val),
        .state      (state)
    );

    assign irq = evt_flag && ctrl_mask;

endmodule

// File: rtl/pt_checker.sv
`timescale 1ns/1ps
module pt_checker
    import periodic_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             ctrl_mask,
    input  logic             load_wr,
    input  logic             tick,
    input  logic             zero_evt,
    input  logic             evt_flag,
    input  logic             irq,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] load_val,
    input  cnt_state_e       state
);

    // R5: no movement while disabled
    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !load_wr) |=> (cnt_val == $past(cnt_val)));

    // R3: one step down per tick while counting
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && tick && !load_wr) |=> (cnt_val == $past(cnt_val) - 1'b1));

    // R6: a zero event always leaves the flag set
    assert_flag_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> evt_flag);

    // R7: masked timer never interrupts
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_mask |-> !irq);

    // R9: reload on the tick after expiry
    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRED && tick && !load_wr) |=> (cnt_val == $past(load_val)));

    // R5: no ticks leave the prescaler while disabled
    assert_no_tick_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !tick);

endmodule

bind periodic_timer pt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .ctrl_mask (ctrl_mask),
    .load_wr   (load_wr),
    .tick      (tick),
    .zero_evt  (zero_evt),
    .evt_flag  (evt_flag),
    .irq       (irq),
    .cnt_val   (cnt_val),
    .load_val  (load_val),
    .state     (state)
);

// File: tb/tb_periodic_timer.sv
`timescale 1ns/1ps
module tb_periodic_timer;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_PSC  = 3'd1;
    localparam logic [2:0] A_LOAD = 3'd2;
    localparam logic [2:0] A_CNT  = 3'd3;
    localparam logic [2:0] A_EVT  = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_clk_i = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    periodic_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_clk_i (tmr_clk_i),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic quiesce();
        wr(A_CTRL, 32'h0);
        wr(A_EVT, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1", $sformatf("reg %0d after reset", a), v, 32'h0);
        end
        check("R1", "irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        quiesce();
        wr(A_PSC, 32'd0);
        wr(A_LOAD, 32'd5);
        rd(A_LOAD, v); check("R2", "load reg", v, 32'd5);
        rd(A_CNT, v);  check("R2", "count after load", v, 32'd5);
        wr(A_CTRL, 32'h3);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R3", "irq one edge early", {31'b0, irq}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R3", "irq at 1+L edges", {31'b0, irq}, 32'h1);
        check("R6", "irq with mask set", {31'b0, irq}, 32'h1);
        rd(A_EVT, v); check("R6", "event flag", v, 32'h1);
    endtask

    task automatic t_prescale();
        quiesce();
        wr(A_PSC, 32'd3);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'h3);
        repeat (12) @(posedge clk);
        @(negedge clk);
        check("R4", "irq before 1+L*(P+1)", {31'b0, irq}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R4", "irq at 1+L*(P+1)", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        quiesce();
        wr(A_PSC, 32'd0);
        wr(A_LOAD, 32'd20);
        wr(A_CTRL, 32'h1);
        repeat (5) @(posedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); check("R5", "frozen value", v, 32'd15);
        repeat (10) @(posedge clk);
        rd(A_CNT, v); check("R5", "held while off", v, 32'd15);
        wr(A_CTRL, 32'h1);
        repeat (3) @(posedge clk);
        rd(A_CNT, v); check("R5", "resumed from held value", v, 32'd13);
    endtask

    task automatic t_masked_and_clear();
        logic [31:0] v;
        quiesce();
        wr(A_PSC, 32'd0);
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'h1);
        repeat (10) @(posedge clk);
        wr(A_CTRL, 32'h0);
        rd(A_EVT, v); check("R7", "flag set while masked", v, 32'h1);
        check("R7", "irq low while masked", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h2);
        @(negedge clk);
        check("R7", "irq follows pending flag on unmask", {31'b0, irq}, 32'h1);
        wr(A_EVT, 32'h0);
        rd(A_EVT, v); check("R8", "write 0 keeps flag", v, 32'h1);
        wr(A_EVT, 32'h1);
        rd(A_EVT, v); check("R8", "write 1 clears flag", v, 32'h0);
        check("R8", "irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        quiesce();
        wr(A_PSC, 32'd0);
        wr(A_LOAD, 32'd4);
        wr(A_CTRL, 32'h3);
        repeat (5) @(posedge clk);
        rd(A_CNT, v); check("R9", "count at zero", v, 32'd0);
        rd(A_CNT, v); check("R9", "count reloaded next tick", v, 32'd4);
        rd(A_CNT, v); check("R9", "counting after reload", v, 32'd3);
    endtask

    task automatic ext_edge();
        @(negedge clk); tmr_clk_i = 1'b1;
        repeat (4) @(negedge clk);
        tmr_clk_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_extclk();
        logic [31:0] v;
        quiesce();
        wr(A_PSC, 32'd0);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'h7);
        repeat (20) @(posedge clk);
        rd(A_CNT, v); check("R10", "held without timer edges", v, 32'd3);
        ext_edge();
        rd(A_CNT, v); check("R10", "one decrement per edge", v, 32'd2);
        ext_edge();
        ext_edge();
        rd(A_CNT, v); check("R10", "zero after three edges", v, 32'd0);
        check("R10", "irq from timer clock", {31'b0, irq}, 32'h1);
        ext_edge();
        rd(A_CNT, v); check("R9", "reload on next timer edge", v, 32'd3);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        quiesce();
        wr(A_PSC, 32'd7);
        wr(A_LOAD, 32'd9);
        wr(A_CNT, 32'h55);
        rd(A_CNT, v); check("R11", "count read-only", v, 32'd9);
        for (int a = 5; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R11", "ctrl untouched", v, 32'h0);
        rd(A_PSC, v);  check("R11", "psc untouched", v, 32'd7);
        rd(A_LOAD, v); check("R11", "load untouched", v, 32'd9);
        rd(A_EVT, v);  check("R11", "event untouched", v, 32'h0);
        rd(3'd6, v);   check("R11", "unmapped read", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_prescale();
        t_freeze();
        t_masked_and_clear();
        t_reload();
        t_extclk();
        t_decode();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule